// File: doc/BRIEF.md
# Fault Capture and Attention Router

This block collects error pulses from surrounding logic into a sticky 64-bit fault register and turns the unmasked faults into three attention outputs: checkstop, recoverable and unit-checkstop. Each fault bit carries a two-bit action code, one bit taken from each of two action registers, and the code selects which attention output the bit drives. A fourth output is the summary of all three and serves as the unit-level attention line.

Software reaches the block through a small register port: a 3-bit offset, a write strobe, 64-bit write data and combinational read data. Faults are cleared by writing to an AND alias, where every zero bit in the write data clears the matching fault. Mask bits are set by writing to an OR alias. The fault and mask registers can also be written directly at their base offsets, and both action registers are plain read/write registers.

Top module: `fault_attn_unit`

## Requirements
- R1: A synchronous active-high reset clears the fault register and both action registers, sets every mask bit to 1, and drives all four attention outputs to 0.
- R2: A high bit on `err_in` sets the matching fault bit at the next clock edge, and the bit stays set while no write touches the fault register.
- R3: A write to offset 1 ANDs the write data into the fault register, so a 0 in a write data bit clears that fault and a 1 leaves it unchanged.
- R4: If `err_in` is high for a bit in the same cycle that an offset 1 write clears that bit, the bit ends up set.
- R5: A write to offset 3 loads the mask register, a write to offset 5 ORs the write data into the mask, and offset 3 reads the mask.
- R6: Offset 0 reads the fault register and a write there loads it (ORed with `err_in`). Offsets 6 and 7 are the read/write action registers 0 and 1.
- R7: `attn_chk` is high when some fault bit is set, its mask bit is 0, and its action-0 and action-1 bits are both 0.
- R8: `attn_rec` is high when some fault bit is set, its mask bit is 0, its action-0 bit is 0 and its action-1 bit is 1.
- R9: `attn_ucs` is high when some fault bit is set, its mask bit is 0, and its action-0 and action-1 bits are both 1.
- R10: A fault bit whose action-0 bit is 1 and action-1 bit is 0 raises no attention output.
- R11: A fault bit whose mask bit is 1 raises no attention output.
- R12: Each attention output is registered. It reflects the fault, mask and action register values held during the previous cycle, so it changes one clock edge after those registers do.
- R13: Reads of offsets 1, 2, 4 and 5 return zero.
- R14: `attn_any` is high exactly when at least one of `attn_chk`, `attn_rec` or `attn_ucs` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe for the offset on `reg_addr` |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| err_in | input | 64 | Error pulses, one per fault bit |
| attn_chk | output | 1 | Checkstop attention |
| attn_rec | output | 1 | Recoverable attention |
| attn_ucs | output | 1 | Unit-checkstop attention |
| attn_any | output | 1 | Summary of the three attention outputs |

## Verification
The checker assumes that reset is held for at least one clock edge before checking starts, and that `reg_addr`, `reg_wr`, `reg_wdata` and `err_in` are known and stable at each rising edge. The stickiness property is checked only in cycles with no write to offset 0 or 1. The property that an error input always wins is checked in every cycle, so it also covers the case where a write to offset 0 or 1 lands together with an error pulse. The bench changes inputs only on the falling edge and returns the strobe and the error bus to zero after each step. Its random errors are sparse bit patterns, so the fault register passes through many partly filled states rather than filling up at once.

// File: rtl/fault_attn_pkg.sv
package fault_attn_pkg;

    // Register offsets; software decodes these, so the values are fixed.
    localparam int unsigned OFS_W = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_FAULT     = 3'd0,
        OFS_FAULT_AND = 3'd1,
        OFS_SPARE2    = 3'd2,
        OFS_MASK      = 3'd3,
        OFS_SPARE4    = 3'd4,
        OFS_MASK_OR   = 3'd5,
        OFS_ACT0      = 3'd6,
        OFS_ACT1      = 3'd7
    } reg_ofs_e;

    // Per-bit routing decision.
    typedef struct packed {
        logic chk;
        logic rec;
        logic ucs;
    } attn_route_t;

    // Decode a two-bit action code into attention routes.
    // act0/act1: 00 checkstop, 01 recoverable, 11 unit checkstop, 10 reserved.
    function automatic attn_route_t route_of(input logic act0, input logic act1);
        attn_route_t r;
        r.chk = ~act0 & ~act1;
        r.rec = ~act0 &  act1;
        r.ucs =  act0 &  act1;
        return r;
    endfunction

    // Register-port write request as seen by the storage blocks.
    typedef struct packed {
        logic          en;
        reg_ofs_e      ofs;
    } wr_req_t;

endpackage

// File: rtl/fir_capture.sv
module fir_capture
    import fault_attn_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_req_t      wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] err_in,
    output logic [W-1:0] fault_q,
    output logic [W-1:0] mask_q
);

    logic [W-1:0] fault_base;
    logic [W-1:0] mask_d;

    // Software term first, then error inputs ORed on top so they win.
    always_comb begin
        fault_base = fault_q;
        if (wr.en && wr.ofs == OFS_FAULT)     fault_base = wdata;
        if (wr.en && wr.ofs == OFS_FAULT_AND) fault_base = fault_q & wdata;
    end

    always_comb begin
        mask_d = mask_q;
        if (wr.en && wr.ofs == OFS_MASK)    mask_d = wdata;
        if (wr.en && wr.ofs == OFS_MASK_OR) mask_d = mask_q | wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= '0;
            mask_q  <= '1;
        end else begin
            fault_q <= fault_base | err_in;
            mask_q  <= mask_d;
        end
    end

endmodule

// File: rtl/fir_action.sv
module fir_action
    import fault_attn_pkg::*;
#(
    parameter int unsigned W = 64,
    parameter int unsigned N_ACT = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_req_t      wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] act_q [N_ACT]
);

    localparam reg_ofs_e ACT_OFS [2] = '{OFS_ACT0, OFS_ACT1};

    for (genvar g = 0; g < N_ACT; g++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst)
                act_q[g] <= '0;
            else if (wr.en && wr.ofs == ACT_OFS[g])
                act_q[g] <= wdata;
        end
    end

endmodule

// File: rtl/fir_attn_route.sv
module fir_attn_route
    import fault_attn_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fault,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] act0,
    input  logic [W-1:0] act1,
    output logic         attn_chk,
    output logic         attn_rec,
    output logic         attn_ucs,
    output logic         attn_any
);

    logic [W-1:0] live;
    logic [W-1:0] hit_chk;
    logic [W-1:0] hit_rec;
    logic [W-1:0] hit_ucs;
    logic [W-1:0] hit_any;

    assign live = fault & ~mask;

    for (genvar b = 0; b < W; b++) begin : g_bit
        attn_route_t rt;
        assign rt         = route_of(act0[b], act1[b]);
        assign hit_chk[b] = live[b] & rt.chk;
        assign hit_rec[b] = live[b] & rt.rec;
        assign hit_ucs[b] = live[b] & rt.ucs;
        // Summary taken straight from the code: anything but the reserved one.
        assign hit_any[b] = live[b] & ~(act0[b] & ~act1[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            attn_chk <= 1'b0;
            attn_rec <= 1'b0;
            attn_ucs <= 1'b0;
            attn_any <= 1'b0;
        end else begin
            attn_chk <= |hit_chk;
            attn_rec <= |hit_rec;
            attn_ucs <= |hit_ucs;
            attn_any <= |hit_any;
        end
    end

endmodule

// File: rtl/fault_attn_unit.sv
module fault_attn_unit
    import fault_attn_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic             reg_wr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    input  logic [W-1:0]     err_in,
    output logic             attn_chk,
    output logic             attn_rec,
    output logic             attn_ucs,
    output logic             attn_any
);

    localparam int unsigned N_ACT = 2;

    wr_req_t      wr;
    logic [W-1:0] fault_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] act_q [N_ACT];
    logic [W-1:0] act0_q;
    logic [W-1:0] act1_q;

    assign wr.en  = reg_wr;
    assign wr.ofs = reg_ofs_e'(reg_addr);

    fir_capture #(.W(W)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .wdata  (reg_wdata),
        .err_in (err_in),
        .fault_q(fault_q),
        .mask_q (mask_q)
    );

    fir_action #(.W(W), .N_ACT(N_ACT)) u_action (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .wdata(reg_wdata),
        .act_q(act_q)
    );

    assign act0_q = act_q[0];
    assign act1_q = act_q[1];

    fir_attn_route #(.W(W)) u_route (
        .clk     (clk),
        .rst     (rst),
        .fault   (fault_q),
        .mask    (mask_q),
        .act0    (act0_q),
        .act1    (act1_q),
        .attn_chk(attn_chk),
        .attn_rec(attn_rec),
        .attn_ucs(attn_ucs),
        .attn_any(attn_any)
    );

    always_comb begin
        unique case (wr.ofs)
            OFS_FAULT: reg_rdata = fault_q;
            OFS_MASK:  reg_rdata = mask_q;
            OFS_ACT0:  reg_rdata = act0_q;
            OFS_ACT1:  reg_rdata = act1_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fault_attn_unit_chk.sv
module fault_attn_unit_chk #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   reg_addr,
    input logic         reg_wr,
    input logic [W-1:0] err_in,
    input logic [W-1:0] fault_q,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] act0_q,
    input logic [W-1:0] act1_q,
    input logic         attn_chk,
    input logic         attn_rec,
    input logic         attn_ucs,
    input logic         attn_any
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fault_q == '0 && mask_q == '1 && act0_q == '0 && act1_q == '0
                        && !attn_any));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1))
        |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

    assert_input_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (err_in != '0) |=> ((fault_q & $past(err_in)) == $past(err_in)));

    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(mask_q) == '1) |-> (!attn_chk && !attn_rec && !attn_ucs));

    assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ($past((fault_q & ~mask_q & ~(act0_q & ~act1_q)) == '0)) |-> !attn_any);

    assert_chk_delay_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(attn_chk) |-> $past(|(fault_q & ~mask_q & ~act0_q & ~act1_q)));

    assert_summary_R14: assert property (@(posedge clk) disable iff (rst)
        attn_any == (attn_chk | attn_rec | attn_ucs));

endmodule

bind fault_attn_unit fault_attn_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_addr(reg_addr),
    .reg_wr  (reg_wr),
    .err_in  (err_in),
    .fault_q (fault_q),
    .mask_q  (mask_q),
    .act0_q  (act0_q),
    .act1_q  (act1_q),
    .attn_chk(attn_chk),
    .attn_rec(attn_rec),
    .attn_ucs(attn_ucs),
    .attn_any(attn_any)
);

// File: tb/fault_attn_unit_bench.sv
module fault_attn_unit_bench;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic [2:0]   reg_addr;
    logic         reg_wr;
    logic [W-1:0] reg_wdata;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] err_in;
    logic         attn_chk, attn_rec, attn_ucs, attn_any;

    always #5 clk = ~clk;

    fault_attn_unit #(.W(W)) u_fault_attn_unit (
        .clk      (clk),
        .rst      (rst),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .err_in   (err_in),
        .attn_chk (attn_chk),
        .attn_rec (attn_rec),
        .attn_ucs (attn_ucs),
        .attn_any (attn_any)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference state kept by the bench from the requirements.
    logic [W-1:0] m_f, m_m, m_a0, m_a1;

    // {any, ucs, rec, chk}
    function automatic logic [3:0] exp_attn(input logic [W-1:0] f, m, a0, a1);
        logic c, r, u;
        c = |(f & ~m & ~a0 & ~a1);
        r = |(f & ~m & ~a0 &  a1);
        u = |(f & ~m &  a0 &  a1);
        return {c | r | u, u, r, c};
    endfunction

    function automatic logic [W-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_f;
            3'd3:    return m_m;
            3'd6:    return m_a0;
            3'd7:    return m_a1;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called on a falling edge; applies one cycle of stimulus and checks the
    // attention outputs against the state held before that edge.
    task automatic step(input logic [2:0] a, input logic wr, input logic [W-1:0] wd,
                        input logic [W-1:0] e, input string tag);
        logic [3:0] ea;
        reg_addr  = a;
        reg_wr    = wr;
        reg_wdata = wd;
        err_in    = e;
        ea = exp_attn(m_f, m_m, m_a0, m_a1);
        @(posedge clk);
        if (wr) begin
            case (a)
                3'd0: m_f  = wd;
                3'd1: m_f  = m_f & wd;
                3'd3: m_m  = wd;
                3'd5: m_m  = m_m | wd;
                3'd6: m_a0 = wd;
                3'd7: m_a1 = wd;
                default: ;
            endcase
        end
        m_f = m_f | e;
        @(negedge clk);
        reg_wr = 1'b0;
        err_in = '0;
        check(tag, {60'd0, attn_any, attn_ucs, attn_rec, attn_chk}, {60'd0, ea});
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        reg_addr = a;
        reg_wr   = 1'b0;
        #1;
        check(tag, reg_rdata, exp_read(a));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0; err_in = '0;
        m_f = '0; m_m = '1; m_a0 = '0; m_a1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd0, "R1 fault");
        rd(3'd3, "R1 mask");
        rd(3'd6, "R1 act0");
        rd(3'd7, "R1 act1");
        check("R1 attn", {60'd0, attn_any, attn_ucs, attn_rec, attn_chk}, '0);

        // R11: errors while fully masked raise nothing
        step(3'd0, 1'b0, '0, 64'h1, "R11 masked err");
        step(3'd0, 1'b0, '0, '0, "R11 masked hold");
        step(3'd1, 1'b1, '0, '0, "R3 clear all");

        // R5: plain mask write, then read
        step(3'd3, 1'b1, '0, '0, "R5 mask load");
        rd(3'd3, "R5 mask read");

        // R6: action codes bit0=00 chk, bit1=01 rec, bit2=11 ucs, bit3=10 reserved
        step(3'd6, 1'b1, 64'h0C, '0, "R6 act0 write");
        step(3'd7, 1'b1, 64'h06, '0, "R6 act1 write");
        rd(3'd6, "R6 act0 read");
        rd(3'd7, "R6 act1 read");

        // R7/R12: checkstop appears one edge after the fault sets
        step(3'd0, 1'b0, '0, 64'h1, "R12 same edge quiet");
        step(3'd0, 1'b0, '0, '0, "R7 checkstop");
        rd(3'd0, "R2 sticky");
        step(3'd0, 1'b0, '0, '0, "R2 still set");

        // R3: AND-clear
        step(3'd1, 1'b1, ~64'h1, '0, "R3 and clear");
        rd(3'd0, "R3 cleared");
        step(3'd0, 1'b0, '0, '0, "R12 drop after clear");

        // R8 recoverable, R9 unit checkstop
        step(3'd0, 1'b0, '0, 64'h2, "R8 set");
        step(3'd0, 1'b0, '0, '0, "R8 recoverable");
        step(3'd1, 1'b1, '0, 64'h4, "R9 set during clear");
        step(3'd0, 1'b0, '0, '0, "R9 unit checkstop");

        // R4: error beats a clear of the same bit
        step(3'd1, 1'b1, ~64'h4, 64'h4, "R4 collide");
        rd(3'd0, "R4 input wins");
        step(3'd1, 1'b1, '0, '0, "R4 clear all");

        // R10: reserved code raises nothing
        step(3'd0, 1'b0, '0, 64'h8, "R10 set");
        step(3'd0, 1'b0, '0, '0, "R10 reserved quiet");
        check("R10 attn_any", {63'd0, attn_any}, '0);
        step(3'd1, 1'b1, '0, '0, "R10 clear");

        // R5/R11: OR-set mask, then masked bit stays quiet
        step(3'd5, 1'b1, 64'h4, '0, "R5 mask or");
        rd(3'd3, "R5 mask or read");
        step(3'd0, 1'b0, '0, 64'h4, "R11 set masked");
        step(3'd0, 1'b0, '0, '0, "R11 masked quiet");

        // R6: direct fault write
        step(3'd0, 1'b1, 64'h3, '0, "R6 fault load");
        rd(3'd0, "R6 fault read");
        step(3'd0, 1'b0, '0, '0, "R14 summary");

        // R13: unused offsets
        rd(3'd1, "R13 ofs1");
        rd(3'd2, "R13 ofs2");
        rd(3'd4, "R13 ofs4");
        rd(3'd5, "R13 ofs5");

        // Random phase covering R2-R14 against the reference
        for (int i = 0; i < 600; i++) begin
            logic [2:0]   a;
            logic         w;
            logic [W-1:0] wd, e;
            a  = 3'($urandom_range(0, 7));
            w  = ($urandom_range(0, 9) < 3);
            wd = {$urandom, $urandom};
            if (a == 3'd5 && ($urandom_range(0, 3) != 0)) wd = wd & {$urandom, $urandom} & {$urandom, $urandom};
            if (a == 3'd1) wd = wd | {$urandom, $urandom};
            e  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            if ($urandom_range(0, 1) == 0) e = '0;
            step(a, w, wd, e, "R7/R8/R9/R14 random attn");
            rd(3'($urandom_range(0, 7)), "R2/R5/R13 random read");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule